// File: doc/BRIEF.md
# Card Option-Select Register Bank

This block holds the option-select registers of a plug-in expansion card. It sits on a byte-wide host I/O bus and takes eight consecutive offsets. Two read-only bytes carry a fixed card identifier, so that probing software can recognise the card at whatever I/O base it was strapped to. A control byte switches the card's shared memory and its boot memory on or off, independently of each other. A page byte places a 16 KB shared-memory window in a 20-bit host memory space. A further byte holds the interrupt selection.

The block also compares every host memory address against the programmed window and flags a hit. A hit needs three things: the card must be enabled, the address page must equal the stored page, and the stored page must lie in the legal window range, 0xA0000 to 0xFC000. Read data and the hit flag are both registered.

Top module: `optsel_cfg_bank`

## Requirements
- R1: While `rst` is high, and on the clock edge where it is sampled, the control, page and interrupt registers clear to zero and `io_rdata` and `mem_hit` go to 0. The card is then disabled (`card_enable`=0), the boot memory is enabled (`boot_enable`=1) and `irq_select`=0.
- R2: A read (`io_sel`=1, `io_wr`=0) of offset 0 returns 0xFD, and a read of offset 1 returns 0x6A. The value appears on `io_rdata` after the clock edge that samples the read.
- R3: Writes to offsets 0, 1, 5, 6 and 7 change no register, and reads of offsets 5, 6 and 7 return 0x00.
- R4: Offset 2 stores bits 1:0 of the written byte and reads back with bits 7:2 as zero. Bit 0 set makes `card_enable`=1. Bit 1 set makes `boot_enable`=0. Both outputs follow from the clock edge of the write.
- R5: Offset 3 stores the low six bits of the written byte as the window page, which is host address bits 19:14. It reads back with bits 7:6 as zero.
- R6: Offset 4 stores all eight bits. They read back unchanged and drive `irq_select` from the edge of the write.
- R7: `mem_hit` is registered, one cycle behind `mem_addr`. It is 1 only when `card_enable` was 1, `mem_addr[19:14]` equalled the stored page, and the page was at least 0x28 (window base 0xA0000).
- R8: `io_rdata` holds its last value in every cycle without a read strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| io_sel | input | 1 | I/O access strobe for this bank |
| io_wr | input | 1 | 1 = write, 0 = read, when strobed |
| io_offs | input | 3 | Register offset within the bank |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Registered read data |
| mem_addr | input | 20 | Host memory address being decoded |
| mem_hit | output | 1 | Registered window hit |
| card_enable | output | 1 | Shared memory enabled |
| boot_enable | output | 1 | Boot memory enabled |
| irq_select | output | 8 | Stored interrupt selection |

## Verification
Read data and the hit flag are each due one clock edge after the read strobe or the address is sampled. Register effects on `card_enable`, `boot_enable` and `irq_select` are visible right after the edge that takes the write. The bench changes inputs on the falling edge and compares every result at the following falling edge, which is half a period after the edge that produced it. A hit is therefore always judged against the register contents of the cycle before, never against a write in the same cycle. The hold check for R8 leaves the strobe low for several cycles while the offset and write data change underneath.

// File: rtl/optsel_pkg.sv
package optsel_pkg;
  localparam logic [2:0] OFS_ID_LO = 3'd0;
  localparam logic [2:0] OFS_ID_HI = 3'd1;
  localparam logic [2:0] OFS_CTRL  = 3'd2;
  localparam logic [2:0] OFS_PAGE  = 3'd3;
  localparam logic [2:0] OFS_IRQ   = 3'd4;

  typedef struct packed {
    logic boot_off;
    logic card_on;
  } ctrl_t;
endpackage

// File: rtl/optsel_regfile.sv
module optsel_regfile
  import optsel_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int PAGE_W = 6,
  parameter logic [DATA_W-1:0] ID_LO = 8'hFD,
  parameter logic [DATA_W-1:0] ID_HI = 8'h6A
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              io_sel,
  input  logic              io_wr,
  input  logic [2:0]        io_offs,
  input  logic [DATA_W-1:0] io_wdata,
  output logic [DATA_W-1:0] io_rdata,
  output ctrl_t             ctrl_q,
  output logic [PAGE_W-1:0] page_q,
  output logic [DATA_W-1:0] irq_q
);
  localparam int PAD_CTRL = DATA_W - 2;
  localparam int PAD_PAGE = DATA_W - PAGE_W;

  logic              wr_stb, rd_stb;
  logic [DATA_W-1:0] rd_mux;

  assign wr_stb = io_sel &&  io_wr;
  assign rd_stb = io_sel && !io_wr;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0;
      page_q <= '0;
      irq_q  <= '0;
    end else if (wr_stb) begin
      case (io_offs)
        OFS_CTRL: ctrl_q <= ctrl_t'(io_wdata[1:0]);
        OFS_PAGE: page_q <= io_wdata[PAGE_W-1:0];
        OFS_IRQ:  irq_q  <= io_wdata;
        default:  ;
      endcase
    end
  end

  always_comb begin
    case (io_offs)
      OFS_ID_LO: rd_mux = ID_LO;
      OFS_ID_HI: rd_mux = ID_HI;
      OFS_CTRL:  rd_mux = {{PAD_CTRL{1'b0}}, ctrl_q};
      OFS_PAGE:  rd_mux = {{PAD_PAGE{1'b0}}, page_q};
      OFS_IRQ:   rd_mux = irq_q;
      default:   rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)         io_rdata <= '0;
    else if (rd_stb) io_rdata <= rd_mux;
  end

  p_id_lo_r2: assert property (@(posedge clk) disable iff (rst)
    (rd_stb && io_offs == OFS_ID_LO) |=> io_rdata == ID_LO);
  p_id_hi_r2: assert property (@(posedge clk) disable iff (rst)
    (rd_stb && io_offs == OFS_ID_HI) |=> io_rdata == ID_HI);
  p_ro_write_r3: assert property (@(posedge clk) disable iff (rst)
    (wr_stb && (io_offs < OFS_CTRL || io_offs > OFS_IRQ))
      |=> ($stable(ctrl_q) && $stable(page_q) && $stable(irq_q)));
  p_ctrl_write_r4: assert property (@(posedge clk) disable iff (rst)
    (wr_stb && io_offs == OFS_CTRL) |=> ctrl_q.card_on == $past(io_wdata[0]));
  p_rdata_hold_r8: assert property (@(posedge clk) disable iff (rst)
    !rd_stb |=> $stable(io_rdata));
endmodule

// File: rtl/optsel_win_decode.sv
module optsel_win_decode #(
  parameter int ADDR_W = 20,
  parameter int WIN_LOG = 14,
  parameter int MIN_PAGE = 'h28,
  localparam int PAGE_W = ADDR_W - WIN_LOG
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] mem_addr,
  input  logic              card_on,
  input  logic [PAGE_W-1:0] page_q,
  output logic              mem_hit
);
  logic page_ok, page_eq;

  assign page_eq = mem_addr[ADDR_W-1:WIN_LOG] == page_q;

  generate
    if (MIN_PAGE == 0) begin : g_any_page
      assign page_ok = 1'b1;
    end else begin : g_min_page
      assign page_ok = page_q >= PAGE_W'(MIN_PAGE);
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) mem_hit <= 1'b0;
    else     mem_hit <= card_on && page_ok && page_eq;
  end

  p_hit_needs_card_r7: assert property (@(posedge clk) disable iff (rst)
    mem_hit |-> $past(card_on));
  p_hit_page_r7: assert property (@(posedge clk) disable iff (rst)
    mem_hit |-> ($past(mem_addr[ADDR_W-1:WIN_LOG]) == $past(page_q)));
endmodule

// File: rtl/optsel_cfg_bank.sv
module optsel_cfg_bank
  import optsel_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 20,
  parameter int WIN_LOG = 14,
  parameter int MIN_PAGE = 'h28,
  parameter logic [DATA_W-1:0] ID_LO = 8'hFD,
  parameter logic [DATA_W-1:0] ID_HI = 8'h6A
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              io_sel,
  input  logic              io_wr,
  input  logic [2:0]        io_offs,
  input  logic [DATA_W-1:0] io_wdata,
  output logic [DATA_W-1:0] io_rdata,
  input  logic [ADDR_W-1:0] mem_addr,
  output logic              mem_hit,
  output logic              card_enable,
  output logic              boot_enable,
  output logic [DATA_W-1:0] irq_select
);
  localparam int PAGE_W = ADDR_W - WIN_LOG;

  ctrl_t             ctrl_q;
  logic [PAGE_W-1:0] page_q;

  optsel_regfile #(
    .DATA_W(DATA_W), .PAGE_W(PAGE_W), .ID_LO(ID_LO), .ID_HI(ID_HI)
  ) u_regs (
    .clk(clk), .rst(rst), .io_sel(io_sel), .io_wr(io_wr),
    .io_offs(io_offs), .io_wdata(io_wdata), .io_rdata(io_rdata),
    .ctrl_q(ctrl_q), .page_q(page_q), .irq_q(irq_select)
  );

  optsel_win_decode #(
    .ADDR_W(ADDR_W), .WIN_LOG(WIN_LOG), .MIN_PAGE(MIN_PAGE)
  ) u_dec (
    .clk(clk), .rst(rst), .mem_addr(mem_addr),
    .card_on(ctrl_q.card_on), .page_q(page_q), .mem_hit(mem_hit)
  );

  assign card_enable = ctrl_q.card_on;
  assign boot_enable = !ctrl_q.boot_off;

  p_reset_state_r1: assert property (@(posedge clk)
    $past(rst) |-> (!card_enable && boot_enable && irq_select == '0 && !mem_hit));
endmodule

// File: tb/sim_optsel_cfg_bank.sv
module sim_optsel_cfg_bank;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       io_sel = 1'b0, io_wr = 1'b0;
  logic [2:0] io_offs = '0;
  logic [7:0] io_wdata = '0;
  logic [7:0] io_rdata;
  logic [19:0] mem_addr = '0;
  logic       mem_hit, card_enable, boot_enable;
  logic [7:0] irq_select;

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  optsel_cfg_bank u0 (
    .clk(clk), .rst(rst), .io_sel(io_sel), .io_wr(io_wr), .io_offs(io_offs),
    .io_wdata(io_wdata), .io_rdata(io_rdata), .mem_addr(mem_addr),
    .mem_hit(mem_hit), .card_enable(card_enable), .boot_enable(boot_enable),
    .irq_select(irq_select)
  );

  // vector: {kind(0 write,1 read,2 hit), offs, data, page, expected}
  localparam int NV = 33;
  localparam logic [26:0] VEC [NV] = '{
    {2'd0, 3'd2, 8'h01, 6'h00, 8'h00},
    {2'd0, 3'd3, 8'hFF, 6'h00, 8'h00},
    {2'd1, 3'd3, 8'h00, 6'h00, 8'h3F},
    {2'd1, 3'd2, 8'h00, 6'h00, 8'h01},
    {2'd0, 3'd2, 8'hFF, 6'h00, 8'h00},
    {2'd1, 3'd2, 8'h00, 6'h00, 8'h03},
    {2'd0, 3'd4, 8'hA5, 6'h00, 8'h00},
    {2'd1, 3'd4, 8'h00, 6'h00, 8'hA5},
    {2'd1, 3'd0, 8'h00, 6'h00, 8'hFD},
    {2'd1, 3'd1, 8'h00, 6'h00, 8'h6A},
    {2'd0, 3'd0, 8'h12, 6'h00, 8'h00},
    {2'd0, 3'd1, 8'h34, 6'h00, 8'h00},
    {2'd1, 3'd0, 8'h00, 6'h00, 8'hFD},
    {2'd1, 3'd1, 8'h00, 6'h00, 8'h6A},
    {2'd0, 3'd5, 8'h77, 6'h00, 8'h00},
    {2'd0, 3'd6, 8'hFF, 6'h00, 8'h00},
    {2'd0, 3'd7, 8'h5C, 6'h00, 8'h00},
    {2'd1, 3'd5, 8'h00, 6'h00, 8'h00},
    {2'd1, 3'd6, 8'h00, 6'h00, 8'h00},
    {2'd1, 3'd7, 8'h00, 6'h00, 8'h00},
    {2'd1, 3'd4, 8'h00, 6'h00, 8'hA5},
    {2'd0, 3'd2, 8'h01, 6'h00, 8'h00},
    {2'd0, 3'd3, 8'h33, 6'h00, 8'h00},
    {2'd2, 3'd0, 8'h00, 6'h33, 8'h01},
    {2'd2, 3'd0, 8'h00, 6'h32, 8'h00},
    {2'd0, 3'd2, 8'h02, 6'h00, 8'h00},
    {2'd2, 3'd0, 8'h00, 6'h33, 8'h00},
    {2'd0, 3'd2, 8'h01, 6'h00, 8'h00},
    {2'd0, 3'd3, 8'h27, 6'h00, 8'h00},
    {2'd2, 3'd0, 8'h00, 6'h27, 8'h00},
    {2'd0, 3'd3, 8'h28, 6'h00, 8'h00},
    {2'd2, 3'd0, 8'h00, 6'h28, 8'h01},
    {2'd2, 3'd0, 8'h00, 6'h3F, 8'h00}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  function automatic string read_tag(input logic [2:0] o);
    case (o)
      3'd0, 3'd1: return "R2";
      3'd2: return "R4";
      3'd3: return "R5";
      3'd4: return "R6";
      default: return "R3";
    endcase
  endfunction

  task automatic do_write(input logic [2:0] o, input logic [7:0] d);
    @(negedge clk);
    io_sel = 1'b1; io_wr = 1'b1; io_offs = o; io_wdata = d;
    @(negedge clk);
    io_sel = 1'b0; io_wr = 1'b0;
  endtask

  task automatic do_read(input logic [2:0] o, output logic [7:0] d);
    @(negedge clk);
    io_sel = 1'b1; io_wr = 1'b0; io_offs = o;
    @(negedge clk);
    io_sel = 1'b0;
    d = io_rdata;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] rd;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 rdata", io_rdata, 8'h00);
    chk("R1 hit", mem_hit, 1'b0);
    chk("R1 card_enable", card_enable, 1'b0);
    chk("R1 boot_enable", boot_enable, 1'b1);
    chk("R1 irq_select", irq_select, 8'h00);
    rst = 1'b0;
    do_read(3'd2, rd); chk("R1 ctrl after reset", rd, 8'h00);
    do_read(3'd3, rd); chk("R1 page after reset", rd, 8'h00);

    for (int i = 0; i < NV; i++) begin
      logic [1:0] kind;
      logic [2:0] o;
      logic [7:0] d, e;
      logic [5:0] pg;
      {kind, o, d, pg, e} = VEC[i];
      if (kind == 2'd0) begin
        do_write(o, d);
      end else if (kind == 2'd1) begin
        do_read(o, rd);
        chk(read_tag(o), rd, e);
      end else begin
        @(negedge clk);
        mem_addr = {pg, 14'h0123};
        @(negedge clk);
        chk("R7 hit", mem_hit, e[0]);
        mem_addr = '0;
      end
    end

    // R4/R6 outputs track registers: current ctrl=0x01, irq=0xA5
    chk("R4 card_enable on", card_enable, 1'b1);
    chk("R4 boot_enable on", boot_enable, 1'b1);
    chk("R6 irq_select", irq_select, 8'hA5);
    do_write(3'd2, 8'h02);
    chk("R4 card_enable off", card_enable, 1'b0);
    chk("R4 boot_enable off", boot_enable, 1'b0);

    // R7 edge pages with card on: top page 0x3F valid
    do_write(3'd2, 8'h01);
    do_write(3'd3, 8'h3F);
    @(negedge clk); mem_addr = 20'hFC000;
    @(negedge clk); chk("R7 top page", mem_hit, 1'b1);
    mem_addr = 20'hFBFFF;
    @(negedge clk); chk("R7 below window", mem_hit, 1'b0);
    mem_addr = '0;

    // R8 hold: rdata keeps last read across idle cycles
    do_read(3'd0, rd); chk("R2 id low", rd, 8'hFD);
    @(negedge clk); io_offs = 3'd4; io_wdata = 8'h99;
    repeat (3) @(negedge clk);
    chk("R8 hold", io_rdata, 8'hFD);

    // R1 reset after programming
    @(negedge clk); rst = 1'b1;
    @(negedge clk);
    chk("R1 re-reset card", card_enable, 1'b0);
    chk("R1 re-reset boot", boot_enable, 1'b1);
    chk("R1 re-reset irq", irq_select, 8'h00);
    chk("R1 re-reset rdata", io_rdata, 8'h00);
    rst = 1'b0;

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule